// File: doc/BRIEF.md
# Dual-Mode SPI Register Slave

This block is an SPI slave that gives an external master read and write access to a byte-wide register file. It uses SPI mode (0,0): SCLK idles low, the block samples input bits on rising SCLK edges and changes its output bit on falling edges. Every transfer starts with a command byte, most significant bit first. The command byte carries a register address and a read/write flag. Any number of data bytes follows. The register address steps up by one after each data byte.

The block runs in one of two wiring modes. In full-duplex mode the master sends on MOSI and the slave answers on MISO. In half-duplex mode one wire is shared. For a read command, the slave takes that wire over after the eighth rising SCLK edge, and MISO is never driven. The mode bit sits in a configuration register inside the block, and an SPI write to that register changes it. SCLK, select and MOSI are synchronised into the system clock domain. The system clock must run at least eight times faster than SCLK.

Top module: `spi_dual_reg_slave`

## Requirements
- R1: Read data changes only while SCLK is low and stays stable while SCLK is high.
- R2: Command byte layout: bits 7..3 are the register address, bit 1 selects write (1) or read (0), and bits 2 and 0 have no effect.
- R3: In a write transfer, each completed data byte produces exactly one reg_wr_en pulse carrying its address and the byte.
- R4: In full-duplex mode, read data goes out on miso_out MSB first. The first bit is valid at the ninth rising SCLK edge.
- R5: After each data byte the address rises by one and wraps from 31 to 0.
- R6: In half-duplex mode, a read enables mosi_oe only after the eighth rising edge and shifts the data out on the shared line. miso_oe stays low, and the block never enables both outputs at once.
- R7: In half-duplex mode, a write transfer never enables mosi_oe.
- R8: Raising the select line releases both outputs and aborts the transfer. A partial byte is never written, and the next transfer starts a fresh command.
- R9: Register 31 is the configuration register. Bit 4 selects half-duplex (1) or full-duplex (0), it resets to 0, and it reads back.
- R10: In full-duplex mode, miso_oe is high while the block is selected and mosi_oe stays low.
- R11: Accesses to register 31 are handled inside the block and never pulse reg_wr_en. A read enable and a write enable never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_sel_n | input | 1 | Active-low select |
| mosi_in | input | 1 | Data received from the master (shared line in half-duplex mode) |
| mosi_out | output | 1 | Data sent by the slave on the shared line |
| mosi_oe | output | 1 | Output enable for the shared line |
| miso_out | output | 1 | Data sent by the slave on MISO |
| miso_oe | output | 1 | Output enable for MISO |
| reg_addr | output | 5 | Register file address |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data; must be valid in the same cycle as reg_rd_en |

## Verification
The checks assume that select stays low for a whole transfer. They also assume that SCLK and MOSI change only when the system clock has seen many cycles of the previous level, and that the master stops driving the shared line before the slave enables it. The stimulus meets these conditions by holding each SCLK phase for eight system clocks and changing data only on falling SCLK edges. In half-duplex reads it releases its driver at the eighth rising edge. The register file answers a read combinationally in the same cycle, and the stimulus relies on that.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 5;
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int WR_BIT   = 1;
    localparam int ADDR_MSB = BYTE_W - 1;

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  bit_cnt;
        logic              cmd_done;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic              dout;
    } spi_rs_state_t;
endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb chain_d = {chain_q[STAGES-2:0], din[i]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[i]}};
            else        chain_q <= chain_d;
        end

        assign dout[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_rs_cfg.sv
module spi_rs_cfg
    import spi_rs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CFG_ADDR = 5'd31,
    parameter int                HDX_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] ext_rdata,
    output logic              ext_wr_en,
    output logic              ext_rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              hdx
);
    logic hdx_d, hdx_q;
    logic is_cfg;

    always_comb begin
        is_cfg    = (addr == CFG_ADDR);
        ext_wr_en = wr_req && !is_cfg;
        ext_rd_en = rd_req && !is_cfg;
        rd_data   = is_cfg ? (BYTE_W'(hdx_q) << HDX_BIT) : ext_rdata;
        hdx_d     = hdx_q;
        if (wr_req && is_cfg) hdx_d = wdata[HDX_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hdx_q <= 1'b0;
        else        hdx_q <= hdx_d;
    end

    assign hdx = hdx_q;
endmodule

// File: rtl/spi_dual_reg_slave.sv
module spi_dual_reg_slave
    import spi_rs_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CFG_ADDR    = 5'd31,
    parameter int                HDX_BIT     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_sel_n,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    output logic              miso_out,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd_en,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [2:0]        sync_o;
    logic              sclk_s, sel_n_s, sdi_s;
    spi_rs_state_t     st_d, st_q;
    logic              rise, fall, last_bit;
    logic              cmd_end, data_end, rd_req, wr_req;
    logic [BYTE_W-1:0] byte_in, rd_data;
    logic [ADDR_W-1:0] acc_addr, addr_inc;
    logic              hdx_mode;

    spi_rs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_sclk, spi_sel_n, mosi_in}),
        .dout (sync_o)
    );
    assign {sclk_s, sel_n_s, sdi_s} = sync_o;

    // access decode, kept apart from the next-state process
    assign rise     = sclk_s && !st_q.sclk_prev && !sel_n_s;
    assign fall     = !sclk_s && st_q.sclk_prev && !sel_n_s;
    assign last_bit = (st_q.bit_cnt == LAST_BIT);
    assign byte_in  = {st_q.rx[BYTE_W-2:0], sdi_s};
    assign addr_inc = st_q.addr + ADDR_W'(1);
    assign cmd_end  = rise && last_bit && !st_q.cmd_done;
    assign data_end = rise && last_bit && st_q.cmd_done;
    assign rd_req   = (cmd_end && !byte_in[WR_BIT]) || (data_end && !st_q.is_wr);
    assign wr_req   = data_end && st_q.is_wr;
    assign acc_addr = cmd_end ? byte_in[ADDR_MSB -: ADDR_W]
                    : (data_end && !st_q.is_wr) ? addr_inc : st_q.addr;

    spi_rs_cfg #(.CFG_ADDR(CFG_ADDR), .HDX_BIT(HDX_BIT)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .rd_req   (rd_req),
        .addr     (acc_addr),
        .wdata    (byte_in),
        .ext_rdata(reg_rdata),
        .ext_wr_en(reg_wr_en),
        .ext_rd_en(reg_rd_en),
        .rd_data  (rd_data),
        .hdx      (hdx_mode)
    );

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        if (sel_n_s) begin
            st_d.bit_cnt  = '0;
            st_d.cmd_done = 1'b0;
            st_d.is_wr    = 1'b0;
            st_d.rx       = '0;
            st_d.tx       = '0;
            st_d.dout     = 1'b0;
        end else if (rise) begin
            st_d.rx      = byte_in;
            st_d.bit_cnt = st_q.bit_cnt + CNT_W'(1);
            if (cmd_end) begin
                st_d.cmd_done = 1'b1;
                st_d.is_wr    = byte_in[WR_BIT];
                st_d.addr     = acc_addr;
            end else if (data_end) begin
                st_d.addr = addr_inc;
            end
            if (rd_req) st_d.tx = rd_data;
        end else if (fall) begin
            st_d.dout = st_q.tx[BYTE_W-1];
            st_d.tx   = {st_q.tx[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_addr  = acc_addr;
    assign reg_wdata = byte_in;
    assign miso_out  = st_q.dout;
    assign mosi_out  = st_q.dout;
    assign miso_oe   = !sel_n_s && !hdx_mode;
    assign mosi_oe   = !sel_n_s && hdx_mode && st_q.cmd_done && !st_q.is_wr;
endmodule

// File: rtl/spi_dual_reg_slave_chk.sv
module spi_dual_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_sel_n,
    input logic mosi_oe,
    input logic miso_oe,
    input logic reg_wr_en,
    input logic reg_rd_en
);
    assert_single_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mosi_oe |-> !miso_oe);

    assert_release_on_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sel_n && $past(spi_sel_n) && $past(spi_sel_n, 2)) |-> (!mosi_oe && !miso_oe));

    assert_access_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |-> !$past(spi_sel_n, 2));

    assert_rd_wr_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    assert_write_keeps_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !mosi_oe);
endmodule

bind spi_dual_reg_slave spi_dual_reg_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sel_n(spi_sel_n),
    .mosi_oe  (mosi_oe),
    .miso_oe  (miso_oe),
    .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en)
);

// File: tb/spi_dual_reg_slave_tb.sv
module spi_dual_reg_slave_tb;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_sel_n = 1'b1;
    logic       m_bit = 1'b0;
    logic       m_oe = 1'b0;
    logic       mosi_in, mosi_out, mosi_oe, miso_out, miso_oe;
    logic [4:0] reg_addr;
    logic       reg_wr_en, reg_rd_en;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] mem [0:31];
    logic [4:0] log_a [0:31];
    logic [7:0] log_d [0:31];
    int         log_n = 0;
    logic [7:0] tx_buf [0:7];
    logic [7:0] rx_buf [0:7];

    int  n_chk = 0, n_fail = 0;
    bit  finished = 0;
    bit  in_txn = 0, in_cmd = 0, mode_hdx = 0, watch = 0;
    int  bad_miso = 0, bad_mosi = 0, bad_cmd = 0, contention = 0, unstable = 0, both_en = 0;
    logic sclk_prev_tb = 0, dout_prev = 0;

    always #5 clk = ~clk;

    assign mosi_in   = mosi_oe ? mosi_out : m_bit;
    assign reg_rdata = mem[reg_addr];

    spi_dual_reg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_sel_n(spi_sel_n),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_out(miso_out), .miso_oe(miso_oe), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en),
        .reg_rdata(reg_rdata)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr_en && log_n < 32) begin
                log_a[log_n] = reg_addr;
                log_d[log_n] = reg_wdata;
                log_n++;
                mem[reg_addr] = reg_wdata;
            end
            if (reg_wr_en && reg_rd_en) both_en++;
            if (m_oe && mosi_oe) contention++;
            if (in_txn && watch && mode_hdx && miso_oe) bad_miso++;
            if (in_txn && watch && !mode_hdx && mosi_oe) bad_mosi++;
            if (in_cmd && mosi_oe) bad_cmd++;
            if (in_txn && spi_sclk && sclk_prev_tb && (miso_out != dout_prev)) unstable++;
            sclk_prev_tb = spi_sclk;
            dout_prev    = miso_out;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] b, input bit rel, input bit hdx_m,
                         output logic [7:0] r, output int oe_cnt);
        oe_cnt = 0;
        for (int i = 7; i >= 0; i--) begin
            m_bit = b[i];
            repeat (H) @(negedge clk);
            spi_sclk = 1'b1;
            r[i] = hdx_m ? (mosi_oe ? mosi_out : 1'bx) : miso_out;
            if (hdx_m ? mosi_oe : miso_oe) oe_cnt++;
            if (rel && i == 0) begin
                m_oe   = 1'b0;
                in_cmd = 1'b0;
            end
            repeat (H) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic txn(input logic [7:0] cmd, input int n, input bit w, output int oe_tot);
        logic [7:0] junk;
        int         oe;
        bit         rd_hdx;
        rd_hdx = mode_hdx && !cmd[1];
        oe_tot = 0;
        watch  = w;
        in_txn = 1'b1;
        in_cmd = 1'b1;
        m_oe   = 1'b1;
        @(negedge clk);
        spi_sel_n = 1'b0;
        xbyte(cmd, rd_hdx, 1'b0, junk, oe);
        in_cmd = 1'b0;
        for (int k = 0; k < n; k++) begin
            xbyte(tx_buf[k], 1'b0, rd_hdx, rx_buf[k], oe);
            oe_tot += oe;
        end
        repeat (H) @(negedge clk);
        spi_sel_n = 1'b1;
        m_oe = 1'b0;
        repeat (4 * H) @(negedge clk);
        in_txn = 1'b0;
    endtask

    task automatic t_reset;
        int oe;
        chk(!miso_oe, "R8", "miso_oe at reset", miso_oe, 0);
        chk(!mosi_oe, "R8", "mosi_oe at reset", mosi_oe, 0);
        chk(!reg_wr_en && !reg_rd_en, "R11", "strobes at reset", {reg_wr_en, reg_rd_en}, 0);
        txn({5'd31, 3'b000}, 1, 1'b1, oe);
        chk(rx_buf[0] == 8'h00, "R9", "config reset value", rx_buf[0], 0);
    endtask

    task automatic t_fdx_write;
        int oe, n0;
        n0 = log_n;
        tx_buf[0] = 8'h3C; tx_buf[1] = 8'hA5; tx_buf[2] = 8'h0F;
        bad_mosi = 0;
        txn({5'd5, 3'b010}, 3, 1'b1, oe);
        chk(log_n == n0 + 3, "R3", "write count", log_n - n0, 3);
        for (int k = 0; k < 3; k++) begin
            chk(log_a[n0+k] == 5'(5 + k), "R5", "write address", log_a[n0+k], 5 + k);
            chk(log_d[n0+k] == tx_buf[k], "R3", "write data", log_d[n0+k], tx_buf[k]);
        end
        chk(bad_mosi == 0, "R10", "mosi_oe in full-duplex", bad_mosi, 0);
    endtask

    task automatic t_fdx_read;
        int oe;
        unstable = 0;
        txn({5'd3, 3'b000}, 2, 1'b1, oe);
        chk(rx_buf[0] == mem[3], "R4", "read byte 0", rx_buf[0], mem[3]);
        chk(rx_buf[1] == mem[4], "R5", "read byte 1", rx_buf[1], mem[4]);
        chk(oe == 16, "R10", "miso_oe during data", oe, 16);
        txn({5'd20, 3'b101}, 1, 1'b1, oe);
        chk(rx_buf[0] == mem[20], "R2", "reserved bits ignored", rx_buf[0], mem[20]);
        chk(unstable == 0, "R1", "output change while SCLK high", unstable, 0);
    endtask

    task automatic t_wrap;
        int oe;
        txn({5'd30, 3'b000}, 3, 1'b1, oe);
        chk(rx_buf[0] == mem[30], "R5", "byte at 30", rx_buf[0], mem[30]);
        chk(rx_buf[1] == 8'h00, "R9", "config via increment", rx_buf[1], 0);
        chk(rx_buf[2] == mem[0], "R5", "wrap to 0", rx_buf[2], mem[0]);
    endtask

    task automatic t_abort;
        logic [7:0] junk;
        int oe, n0;
        n0 = log_n;
        in_txn = 1'b1; m_oe = 1'b1;
        @(negedge clk);
        spi_sel_n = 1'b0;
        xbyte({5'd9, 3'b010}, 1'b0, 1'b0, junk, oe);
        for (int i = 0; i < 5; i++) begin
            m_bit = 1'b1;
            repeat (H) @(negedge clk); spi_sclk = 1'b1;
            repeat (H) @(negedge clk); spi_sclk = 1'b0;
        end
        spi_sel_n = 1'b1;
        repeat (4 * H) @(negedge clk);
        in_txn = 1'b0; m_oe = 1'b0;
        chk(log_n == n0, "R8", "partial byte written", log_n - n0, 0);
        chk(!miso_oe && !mosi_oe, "R8", "outputs after abort", {miso_oe, mosi_oe}, 0);
        tx_buf[0] = 8'h96;
        txn({5'd9, 3'b010}, 1, 1'b1, oe);
        chk(log_n == n0 + 1 && log_a[n0] == 5'd9 && log_d[n0] == 8'h96, "R8",
            "fresh transfer after abort", {log_a[n0], log_d[n0]}, {5'd9, 8'h96});
    endtask

    task automatic t_hdx;
        int oe, n0;
        n0 = log_n;
        tx_buf[0] = 8'h10;
        txn({5'd31, 3'b010}, 1, 1'b0, oe);
        chk(log_n == n0, "R11", "config write forwarded", log_n - n0, 0);
        mode_hdx = 1'b1;
        txn({5'd31, 3'b000}, 1, 1'b1, oe);
        chk(rx_buf[0] == 8'h10, "R9", "config readback", rx_buf[0], 8'h10);
        bad_miso = 0; bad_cmd = 0; contention = 0;
        txn({5'd2, 3'b000}, 2, 1'b1, oe);
        chk(rx_buf[0] == mem[2], "R6", "half-duplex byte 0", rx_buf[0], mem[2]);
        chk(rx_buf[1] == mem[3], "R6", "half-duplex byte 1", rx_buf[1], mem[3]);
        chk(oe == 16, "R6", "mosi_oe during data", oe, 16);
        chk(bad_cmd == 0, "R6", "mosi_oe during command", bad_cmd, 0);
        chk(bad_miso == 0, "R6", "miso_oe in half-duplex", bad_miso, 0);
        chk(contention == 0, "R6", "line contention", contention, 0);
        n0 = log_n;
        bad_mosi = 0;
        tx_buf[0] = 8'h5A;
        txn({5'd12, 3'b010}, 1, 1'b1, oe);
        chk(log_n == n0 + 1 && log_d[n0] == 8'h5A, "R7", "half-duplex write", log_d[n0], 8'h5A);
        chk(oe == 0, "R7", "mosi_oe during write", oe, 0);
        tx_buf[0] = 8'h00;
        txn({5'd31, 3'b010}, 1, 1'b0, oe);
        mode_hdx = 1'b0;
        txn({5'd12, 3'b000}, 1, 1'b1, oe);
        chk(rx_buf[0] == 8'h5A, "R10", "back in full-duplex", rx_buf[0], 8'h5A);
        chk(both_en == 0, "R11", "read and write together", both_en, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 8'(i * 37 + 5);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_fdx_write();
        t_fdx_read();
        t_wrap();
        t_abort();
        t_hdx();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule